// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog that escalates through four timeout stages. A single tick counter advances on every clock cycle while the watchdog is running. Each stage has its own tick limit and its own action. When the counter reaches the limit of the current stage, that stage's action fires. The counter then restarts and the next stage takes over. After the last stage the sequence returns to the first. Software keeps the watchdog quiet by feeding it at regular intervals. A feed restarts the count and returns the sequence to the first stage.

An action can raise an interrupt, pulse a reset for one or both cores, pulse a system reset, or pulse a reset for the always-on domain. Reset pulse widths are selected in nanoseconds and converted to clock cycles from the clock period parameter. A key register guards the configuration against stray writes. A boot-protection bit, set by reset, keeps the watchdog running even while the main enable is clear. A pause option freezes the counter while the sleep input is high.

Top module: `stage_watchdog`

## Requirements
- R1: After reset, the configuration word (address 0) reads 32'h0000_0002: only boot protection (bit 1) is set and every stage action is off. Every stage limit (addresses 1 to 4) reads RESET_LIMIT. The key status (address 6, bit 2) reads 0, which means locked. All outputs are low.
- R2: While the watchdog runs, the counter (read at address 5) increments once per clock cycle. The stage index (address 6, bits 1:0) starts at 0. A stage ends on the clock edge at which the counter has reached that stage's limit, so a stage with limit L lasts L+1 cycles. At that edge the counter returns to 0 and the stage advances, with stage 3 followed by stage 0.
- R3: Each stage has a 3-bit action field in the configuration word: stage k uses bits [13+3k+2:13+3k]. Code 1 raises the interrupt. Code 2 pulses the core resets. Code 3 pulses the system reset. Code 4 pulses the always-on reset, using the system pulse width. Code 0 takes no action.
- R4: Any write to address 5 feeds the watchdog. After that edge the counter reads 0 and the stage reads 0, even while the block is locked.
- R5: Writing UNLOCK_KEY to address 6 unlocks the block. Writing any other value to address 6 locks it. While the block is locked, writes to addresses 0 to 4 have no effect.
- R6: The configuration word selects two 3-bit width codes: bits 9:7 for the core reset and bits 12:10 for the system reset. Codes 0 to 7 give 100, 200, 300, 400, 500, 800, 1600 and 3200 ns. Each pulse lasts that time divided by CLK_NS, rounded up, in cycles. The pulse starts in the cycle after the timeout edge.
- R7: The counter runs when the enable bit (bit 0) or the boot-protection bit (bit 1) is set. With both bits clear, the counter holds its value.
- R8: The counter and the stage hold their values while the pause bit (bit 2) and the sleep input are both high.
- R9: The code-2 action pulses core0Rst only if bit 3 was set when the action fired. It pulses core1Rst only if bit 4 was set when the action fired.
- R10: The interrupt register is at address 7. Bit 0 is the interrupt enable. Writing 1 to bit 1 clears the status. A read returns {status, enable} in bits 1:0. A code-1 timeout sets the status. irqOut follows status AND enable when level mode (bit 6) is set. With edge mode (bit 5) and the enable set, irqOut pulses high for one cycle at each code-1 timeout. Writes to address 7 are accepted while the block is locked.
- R11: Action codes 5 to 7 take no action. The stage still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| sleepIn | input | 1 | High while the system sleeps |
| irqOut | output | 1 | Watchdog interrupt |
| core0Rst | output | 1 | Reset pulse for core 0 |
| core1Rst | output | 1 | Reset pulse for core 1 |
| sysRst | output | 1 | System reset pulse |
| aonRst | output | 1 | Always-on domain reset pulse |

## Verification
A stage pointer that advances at the wrong time or wraps wrongly shows up at the ports within one stage period. The action of the wrong stage fires, or fires one cycle early or late, and this shows on a reset or interrupt pin within the same cycle. A wrong width code shows as a pulse whose length differs by at least one cycle. A lock that lets writes through, or a feed that does not clear the count, shows at once in the readback of the limit, count or stage registers. Pause or boot-protection faults show as a count that moves when it should hold, or holds when it should move, after only a few cycles.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;

  localparam int NSTAGE = 4;

  localparam logic [2:0] ACT_OFF = 3'd0;
  localparam logic [2:0] ACT_IRQ = 3'd1;
  localparam logic [2:0] ACT_CPU = 3'd2;
  localparam logic [2:0] ACT_SYS = 3'd3;
  localparam logic [2:0] ACT_AON = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic       clearCnt;
    logic       incCnt;
    logic       fireCpu;
    logic       fireSys;
    logic       fireAon;
    logic [2:0] cpuLen;
    logic [2:0] sysLen;
    logic       core0En;
    logic       core1En;
  } dpStrobe_t;

  function automatic int unsigned widthNs(input logic [2:0] code);
    case (code)
      3'd0:    widthNs = 100;
      3'd1:    widthNs = 200;
      3'd2:    widthNs = 300;
      3'd3:    widthNs = 400;
      3'd4:    widthNs = 500;
      3'd5:    widthNs = 800;
      3'd6:    widthNs = 1600;
      default: widthNs = 3200;
    endcase
  endfunction

  function automatic int unsigned widthCycles(input logic [2:0] code, input int unsigned clkNs);
    return (widthNs(code) + clkNs - 1) / clkNs;
  endfunction

endpackage

// File: rtl/swd_datapath.sv
`timescale 1ns/1ps
module swd_datapath
  import swd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CLK_NS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] cntOut,
  output logic              core0Rst,
  output logic              core1Rst,
  output logic              sysRst,
  output logic              aonRst
);

  localparam int MAX_PULSE = (3200 + CLK_NS - 1) / CLK_NS;
  localparam int PW        = $clog2(MAX_PULSE + 1);
  localparam int NCH       = 3;   // 0: cpu, 1: sys, 2: always-on

  logic [DATA_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.clearCnt) cnt <= '0;
    else if (strobe.incCnt)   cnt <= cnt + 1'b1;
  end

  assign cntOut = cnt;

  logic [NCH-1:0]      chFire;
  logic [2:0]          chCode [NCH];
  logic [NCH-1:0]      chOn;

  assign chFire    = {strobe.fireAon, strobe.fireSys, strobe.fireCpu};
  assign chCode[0] = strobe.cpuLen;
  assign chCode[1] = strobe.sysLen;
  assign chCode[2] = strobe.sysLen;

  generate
    for (genvar g = 0; g < NCH; g++) begin : gPulse
      logic [PW-1:0] pulseCnt;
      logic [PW-1:0] loadVal;

      assign loadVal = PW'(widthCycles(chCode[g], CLK_NS));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                pulseCnt <= '0;
        else if (chFire[g])       pulseCnt <= loadVal;
        else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;
      end

      assign chOn[g] = (pulseCnt != '0);

      AST_PULSE_LOADED: assert property (@(posedge clk) disable iff (!rstN)
        chFire[g] |=> (pulseCnt != '0)); // R6
    end
  endgenerate

  logic [1:0] coreMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              coreMask <= '0;
    else if (strobe.fireCpu) coreMask <= {strobe.core1En, strobe.core0En};
  end

  assign core0Rst = chOn[0] & coreMask[0];
  assign core1Rst = chOn[0] & coreMask[1];
  assign sysRst   = chOn[1];
  assign aonRst   = chOn[2];

  AST_CORE1_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fireCpu && !strobe.core1En) |=> !core1Rst); // R9

endmodule

// File: rtl/swd_ctrl.sv
`timescale 1ns/1ps
module swd_ctrl
  import swd_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 32'h50D8_3AA1,
  parameter logic [DATA_W-1:0] RESET_LIMIT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sleepIn,
  input  logic [DATA_W-1:0] cntIn,
  output dpStrobe_t         strobe,
  output logic              irqOut
);

  localparam int STG_W      = $clog2(NSTAGE);
  localparam int BIT_EN     = 0;
  localparam int BIT_BOOT   = 1;
  localparam int BIT_PAUSE  = 2;
  localparam int BIT_C0     = 3;
  localparam int BIT_C1     = 4;
  localparam int BIT_EDGE   = 5;
  localparam int BIT_LEVEL  = 6;
  localparam int CPULEN_LSB = 7;
  localparam int SYSLEN_LSB = 10;
  localparam int ACT_LSB    = 13;
  localparam int CFG_W      = ACT_LSB + 3 * NSTAGE;

  localparam logic [2:0] ADDR_CFG  = 3'd0;
  localparam logic [2:0] ADDR_LIM0 = 3'd1;
  localparam logic [2:0] ADDR_FEED = 3'd5;
  localparam logic [2:0] ADDR_KEY  = 3'd6;
  localparam logic [2:0] ADDR_IRQ  = 3'd7;

  localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(1) << BIT_BOOT;

  logic [CFG_W-1:0]  cfgReg;
  logic [DATA_W-1:0] limitReg [NSTAGE];
  logic [STG_W-1:0]  stage;
  logic              unlocked;
  logic              irqEn;
  logic              irqStatus;
  logic              irqPulse;
  logic [2:0]        actOf [NSTAGE];

  generate
    for (genvar g = 0; g < NSTAGE; g++) begin : gAct
      assign actOf[g] = cfgReg[ACT_LSB + 3*g +: 3];
    end
  endgenerate

  logic       feedReq;
  logic       cfgWr;
  logic       running;
  logic       timeout;
  logic [2:0] curAct;

  assign feedReq = regWe && (regAddr == ADDR_FEED);
  assign cfgWr   = regWe && unlocked && (regAddr < ADDR_FEED);
  assign running = (cfgReg[BIT_EN] | cfgReg[BIT_BOOT]) & ~(cfgReg[BIT_PAUSE] & sleepIn);
  assign curAct  = actOf[stage];
  assign timeout = running && !feedReq && (cntIn >= limitReg[stage]);

  // key register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              unlocked <= 1'b0;
    else if (regWe && regAddr == ADDR_KEY)  unlocked <= (regWdata == UNLOCK_KEY);
  end

  // protected configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= CFG_RESET;
      for (int k = 0; k < NSTAGE; k++) limitReg[k] <= RESET_LIMIT;
    end else if (cfgWr) begin
      if (regAddr == ADDR_CFG) cfgReg <= regWdata[CFG_W-1:0];
      for (int k = 0; k < NSTAGE; k++)
        if (regAddr == ADDR_LIM0 + 3'(k)) limitReg[k] <= regWdata;
    end
  end

  // stage sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        stage <= '0;
    else if (feedReq) stage <= '0;
    else if (timeout) stage <= (stage == STG_W'(NSTAGE - 1)) ? '0 : stage + 1'b1;
  end

  // interrupt
  logic irqFire;
  logic irqWr;
  assign irqFire = timeout && (curAct == ACT_IRQ);
  assign irqWr   = regWe && (regAddr == ADDR_IRQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn     <= 1'b0;
      irqStatus <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      if (irqWr) irqEn <= regWdata[0];
      if (irqFire)                  irqStatus <= 1'b1;
      else if (irqWr && regWdata[1]) irqStatus <= 1'b0;
      irqPulse <= irqFire && irqEn && cfgReg[BIT_EDGE];
    end
  end

  assign irqOut = irqPulse | (irqStatus & irqEn & cfgReg[BIT_LEVEL]);

  // strobes to datapath
  always_comb begin
    strobe          = '0;
    strobe.clearCnt = feedReq | timeout;
    strobe.incCnt   = running & ~(feedReq | timeout);
    strobe.fireCpu  = timeout && (curAct == ACT_CPU);
    strobe.fireSys  = timeout && (curAct == ACT_SYS);
    strobe.fireAon  = timeout && (curAct == ACT_AON);
    strobe.cpuLen   = cfgReg[CPULEN_LSB +: 3];
    strobe.sysLen   = cfgReg[SYSLEN_LSB +: 3];
    strobe.core0En  = cfgReg[BIT_C0];
    strobe.core1En  = cfgReg[BIT_C1];
  end

  // readback
  always_comb begin
    case (regAddr)
      ADDR_CFG:  regRdata = DATA_W'(cfgReg);
      3'd1:      regRdata = limitReg[0];
      3'd2:      regRdata = limitReg[1];
      3'd3:      regRdata = limitReg[2];
      3'd4:      regRdata = limitReg[3];
      ADDR_FEED: regRdata = cntIn;
      ADDR_KEY:  regRdata = DATA_W'({unlocked, stage});
      default:   regRdata = DATA_W'({irqStatus, irqEn});
    endcase
  end

  AST_FEED_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    feedReq |=> (cntIn == '0 && stage == '0)); // R4
  AST_STAGE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && stage == STG_W'(NSTAGE - 1)) |=> (stage == '0)); // R2
  AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(cfgReg)); // R5
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg[BIT_PAUSE] && sleepIn && !feedReq) |=> ($stable(cntIn) && $stable(stage))); // R8
  AST_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqFire |=> irqStatus); // R10

endmodule

// File: rtl/stage_watchdog.sv
`timescale 1ns/1ps
module stage_watchdog
  import swd_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                CLK_NS      = 10,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 32'h50D8_3AA1,
  parameter logic [DATA_W-1:0] RESET_LIMIT = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sleepIn,
  output logic              irqOut,
  output logic              core0Rst,
  output logic              core1Rst,
  output logic              sysRst,
  output logic              aonRst
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] cnt;

  swd_ctrl #(
    .DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY), .RESET_LIMIT(RESET_LIMIT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sleepIn(sleepIn),
    .cntIn(cnt), .strobe(strobe), .irqOut(irqOut)
  );

  swd_datapath #(
    .DATA_W(DATA_W), .CLK_NS(CLK_NS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cntOut(cnt),
    .core0Rst(core0Rst), .core1Rst(core1Rst), .sysRst(sysRst), .aonRst(aonRst)
  );

endmodule

// File: tb/test_stage_watchdog.sv
`timescale 1ns/1ps
module test_stage_watchdog;

  localparam logic [31:0] KEY = 32'h50D8_3AA1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sleepIn = 1'b0;
  logic        irqOut, core0Rst, core1Rst, sysRst, aonRst;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int c0Cnt = 0, c1Cnt = 0, sysCnt = 0, aonCnt = 0, irqCnt = 0;

  always #2 clk = ~clk;   // 250 MHz

  stage_watchdog #(.CLK_NS(4)) i_stage_watchdog (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sleepIn(sleepIn),
    .irqOut(irqOut), .core0Rst(core0Rst), .core1Rst(core1Rst),
    .sysRst(sysRst), .aonRst(aonRst)
  );

  always @(negedge clk) begin
    if (core0Rst) c0Cnt++;
    if (core1Rst) c1Cnt++;
    if (sysRst)   sysCnt++;
    if (aonRst)   aonCnt++;
    if (irqOut)   irqCnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic int expW(input int code);
    int ns;
    case (code)
      0: ns = 100; 1: ns = 200; 2: ns = 300; 3: ns = 400;
      4: ns = 500; 5: ns = 800; 6: ns = 1600; default: ns = 3200;
    endcase
    return (ns + 3) / 4;
  endfunction

  function automatic logic [31:0] mkCfg(input bit en, input bit boot, input bit pause,
      input bit c0, input bit c1, input bit edg, input bit lvl,
      input int cpuL, input int sysL, input int a0, input int a1, input int a2, input int a3);
    logic [31:0] v;
    v = '0;
    v[0] = en; v[1] = boot; v[2] = pause; v[3] = c0; v[4] = c1; v[5] = edg; v[6] = lvl;
    v[9:7] = 3'(cpuL); v[12:10] = 3'(sysL);
    v[15:13] = 3'(a0); v[18:16] = 3'(a1); v[21:19] = 3'(a2); v[24:22] = 3'(a3);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // stop, feed, set limits, then start: counting begins after the last write edge
  task automatic startRun(input logic [31:0] cfg, input int l0, input int l1, input int l2, input int l3);
    wr(3'd0, cfg & ~32'h3);
    wr(3'd5, 32'h0);
    wr(3'd1, l0); wr(3'd2, l1); wr(3'd3, l2); wr(3'd4, l3);
    wr(3'd0, cfg);
  endtask

  logic [31:0] d;
  int b0, b1, bs, ba, bi;

  task automatic snap();
    b0 = c0Cnt; b1 = c1Cnt; bs = sysCnt; ba = aonCnt; bi = irqCnt;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, d); check("R1 cfg reset", d, 32'h2);
    rd(3'd1, d); check("R1 limit reset", d, 32'hFFFF_FFFF);
    rd(3'd6, d); check("R1 locked stage0", d, 32'h0);
    check("R1 outputs low", {27'b0, irqOut, core0Rst, core1Rst, sysRst, aonRst}, 32'h0);

    // R5 write protection
    wr(3'd1, 32'd5);
    rd(3'd1, d); check("R5 locked write ignored", d, 32'hFFFF_FFFF);
    wr(3'd6, KEY);
    rd(3'd6, d); check("R5 unlocked flag", d[2], 1'b1);
    wr(3'd1, 32'd3000);
    rd(3'd1, d); check("R5 unlocked write", d, 32'd3000);
    wr(3'd6, 32'h0);
    wr(3'd1, 32'd9);
    rd(3'd1, d); check("R5 relocked ignored", d, 32'd3000);
    wr(3'd6, KEY ^ 32'h1);
    rd(3'd6, d); check("R5 wrong key stays locked", d[2], 1'b0);
    wr(3'd6, KEY);

    // R7 boot protection keeps counting with enable clear
    wr(3'd2, 32'd3000); wr(3'd3, 32'd3000); wr(3'd4, 32'd3000);
    wr(3'd0, mkCfg(0,1,0,0,0,0,0,0,0,0,0,0,0));
    wr(3'd5, 32'h0);
    repeat (20) @(posedge clk);
    rd(3'd5, d); check("R7 boot-protect counts", d, 32'd20);
    rd(3'd6, d); check("R4 feed with boot stage0", d, 32'h4);
    wr(3'd0, mkCfg(0,0,0,0,0,0,0,0,0,0,0,0,0));
    rd(3'd5, d); b0 = d;
    repeat (10) @(posedge clk);
    rd(3'd5, d); check("R7 both clear holds", d, b0);

    // R8 pause in sleep
    sleepIn = 1'b1;
    wr(3'd0, mkCfg(1,0,1,0,0,0,0,0,0,0,0,0,0));
    wr(3'd5, 32'h0);
    repeat (15) @(posedge clk);
    rd(3'd5, d); check("R8 sleep holds counter", d, 32'd0);
    wr(3'd0, mkCfg(1,0,0,0,0,0,0,0,0,0,0,0,0));
    repeat (10) @(posedge clk);
    rd(3'd5, d); check("R8 no pause counts", d, 32'd10);
    sleepIn = 1'b0;

    // R2 stage timing and wrap, limits 2,3,4,5
    startRun(mkCfg(1,0,0,0,0,0,0,0,0,0,0,0,0), 2, 3, 4, 5);
    repeat (2) @(posedge clk);
    rd(3'd6, d); check("R2 still stage0", d[1:0], 2'd0);
    @(posedge clk);
    rd(3'd6, d); check("R2 stage1 after L0+1", d[1:0], 2'd1);
    rd(3'd5, d); check("R2 counter restarted", d, 32'd0);
    repeat (9) @(posedge clk);
    rd(3'd6, d); check("R2 stage3", d[1:0], 2'd3);
    repeat (5) @(posedge clk);
    rd(3'd6, d); check("R2 last cycle stage3", d[1:0], 2'd3);
    @(posedge clk);
    rd(3'd6, d); check("R2 wrap to stage0", d[1:0], 2'd0);
    repeat (4) @(posedge clk);
    // R4 feed mid-sequence
    wr(3'd5, 32'h0);
    rd(3'd5, d); check("R4 feed clears counter", d, 32'd0);
    rd(3'd6, d); check("R4 feed stage0", d[1:0], 2'd0);

    // R10 edge mode
    wr(3'd7, 32'h3);
    startRun(mkCfg(1,0,0,0,0,1,0,0,0,1,0,0,0), 5, 3000, 3000, 3000);
    repeat (5) @(posedge clk);
    #1 check("R10 edge before timeout", irqOut, 1'b0);
    @(posedge clk);
    #1 check("R10 edge pulse high", irqOut, 1'b1);
    @(posedge clk);
    #1 check("R10 edge pulse one cycle", irqOut, 1'b0);
    rd(3'd7, d); check("R10 status set", d, 32'h3);

    // R10 level mode
    wr(3'd7, 32'h3);
    startRun(mkCfg(1,0,0,0,0,0,1,0,0,1,0,0,0), 7, 3000, 3000, 3000);
    repeat (8) @(posedge clk);
    #1 check("R10 level high", irqOut, 1'b1);
    repeat (3) @(posedge clk);
    #1 check("R10 level held", irqOut, 1'b1);
    wr(3'd6, 32'h0);
    wr(3'd7, 32'h0);
    #1 check("R10 enable off masks", irqOut, 1'b0);
    wr(3'd7, 32'h3);
    #1 check("R10 clear while locked", irqOut, 1'b0);
    rd(3'd7, d); check("R10 status cleared", d, 32'h1);
    wr(3'd6, KEY);

    // R6 R9 core reset directed
    snap();
    startRun(mkCfg(1,0,0,1,0,0,0,0,0,2,0,0,0), 10, 3000, 3000, 3000);
    repeat (10) @(posedge clk);
    #1 check("R6 core0 not yet", core0Rst, 1'b0);
    @(posedge clk);
    #1 check("R6 core0 starts", core0Rst, 1'b1);
    repeat (900) @(posedge clk);
    check("R6 core0 width 100ns", c0Cnt - b0, expW(0));
    check("R9 core1 masked", c1Cnt - b1, 0);

    // R3 always-on action uses system width
    snap();
    startRun(mkCfg(1,0,0,0,0,0,0,0,2,4,0,0,0), 6, 3000, 3000, 3000);
    repeat (900) @(posedge clk);
    check("R3 aon width", aonCnt - ba, expW(2));
    check("R3 sys quiet on aon", sysCnt - bs, 0);

    // R11 unused code
    snap();
    startRun(mkCfg(1,0,0,1,1,1,1,7,7,5,0,0,0), 4, 3000, 3000, 3000);
    repeat (50) @(posedge clk);
    check("R11 code5 no outputs", (c0Cnt-b0)+(c1Cnt-b1)+(sysCnt-bs)+(aonCnt-ba)+(irqCnt-bi), 0);
    rd(3'd6, d); check("R11 stage still advances", d[1:0], 2'd1);

    // R6 R9 R3 random
    for (int it = 0; it < 8; it++) begin
      int l, act, cc, sc;
      bit m0, m1;
      l = 3 + ($urandom % 30);
      act = 2 + ($urandom % 3);
      cc = $urandom % 8; sc = $urandom % 8;
      m0 = 1'($urandom % 2); m1 = 1'($urandom % 2);
      snap();
      startRun(mkCfg(1,0,0,m0,m1,0,0,cc,sc,act,0,0,0), l, 3000, 3000, 3000);
      repeat (l + 850) @(posedge clk);
      check("R9 random core0", c0Cnt - b0, (act == 2 && m0) ? expW(cc) : 0);
      check("R9 random core1", c1Cnt - b1, (act == 2 && m1) ? expW(cc) : 0);
      check("R6 random sys", sysCnt - bs, (act == 3) ? expW(sc) : 0);
      check("R3 random aon", aonCnt - ba, (act == 4) ? expW(sc) : 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule